// File: doc/BRIEF.md
# Flash Idle Power Controller

The controller owns the flash supply switch and the flash pad mode, and it decides when the flash may be used. The access logic pulses an activity input on every flash operation. That pulse restarts an idle count. While the flash is powered, a free-running check timer fires at a fixed interval. When the check fires, the controller cuts power if the flash has been idle for longer than the idle limit and no access is in progress.

An access request that arrives while power is off starts a power-up. The supply and pads are enabled first. After a settle delay, every bank marked present receives a reset request, in ascending index order. Each reset is acknowledged by the bank side, and each acknowledge is followed by a short gap before the next bank. Access is granted only when the sequence finishes. A bank that reports a failed reset sends the controller into a fatal state. That state holds until the controller is reset, and access stays ungranted.

Every delay is given in microseconds and scaled by a cycles-per-microsecond parameter.

Top module: `flash_idle_pwr_ctrl`

## Requirements
- R1: During and right after reset, supply, pads, grant, bank resets and fatal are all low.
- R2: An access request sampled while powered off raises supply enable and pad enable at the next edge. Grant stays low.
- R3: The first bank reset request appears exactly SETTLE_US*CYC_PER_US cycles after the supply is enabled.
- R4: Only banks whose present bit is 1 receive a reset request. Requests go in ascending bank index, at most one at a time, and each is held until the acknowledge.
- R5: After a successful acknowledge, the next bank reset request rises exactly GAP_US*CYC_PER_US cycles after the previous one fell.
- R6: Grant rises only after the last present bank's gap has elapsed, or directly after the settle delay when no bank is present. While granted, supply and pads stay high.
- R7: Power goes off only on a check tick, which occurs every CHECK_US*CYC_PER_US cycles from reset. At that tick, more than IDLE_US*CYC_PER_US cycles must have passed since the idle count was last cleared. Supply, pads and grant then fall together.
- R8: An activity pulse clears the idle count. The idle count is also cleared when power-up starts and when grant is reached. While access busy is high, power stays on.
- R9: An acknowledge that arrives with the error flag set raises fatal. Fatal then stays high until reset, and grant never rises.
- R10: While powered off, supply and pads are low, and activity pulses do not power the flash up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| activity_i | input | 1 | One-cycle pulse on each flash operation |
| access_req_i | input | 1 | Request for flash access |
| access_busy_i | input | 1 | An access is in progress; blocks power-down |
| bank_present_i | input | NUM_BANKS | Banks fitted, bit i for bank i |
| rst_ack_i | input | 1 | Bank side finished the requested reset |
| rst_err_i | input | 1 | Qualifies rst_ack_i: reset failed |
| supply_en_o | output | 1 | Flash supply switch enable |
| pad_en_o | output | 1 | Pads in bus function (low: driven-low outputs) |
| bank_rst_o | output | NUM_BANKS | Reset request, bit i for bank i |
| grant_o | output | 1 | Flash ready and access granted |
| fatal_o | output | 1 | Sticky bank reset failure |

## Verification
The bench targets several corner cases, each of which a faulty design would get visibly wrong:
- Bank walk over a sparse present mask. A selector that skips the wrong way would reset an absent bank or miss bank 3 after bank 1.
- Exact settle and gap lengths. An off-by-one in the timers shows up as a request one cycle early or late.
- Idle limit crossed while access busy is held. A design that ignores busy drops power under an active access.
- Power-down alignment. A design that drops power without waiting for the periodic tick falls out of step with the reference model.
- An empty present mask, which must grant right after settling.
- A failing bank. A design that grants after the failure, or clears fatal on a later request, is caught.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_SETTLE = 3'd1,
    ST_RST    = 3'd2,
    ST_GAP    = 3'd3,
    ST_ON     = 3'd4,
    ST_FAULT  = 3'd5
  } pwr_st_e;
endpackage

// File: rtl/fpc_timer.sv
module fpc_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fpc_idle_mon.sv
module fpc_idle_mon #(
  parameter int IDLE_CYC  = 1000,
  parameter int CHECK_CYC = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic idle_over_o,
  output logic tick_o
);
  localparam int IW = $clog2(IDLE_CYC + 2);
  localparam int CW = $clog2(CHECK_CYC + 1);
  localparam logic [IW-1:0] IDLE_LIM = IW'(IDLE_CYC);
  localparam logic [CW-1:0] CHK_LAST = CW'(CHECK_CYC - 1);

  logic [IW-1:0] idle_q;
  logic [CW-1:0] chk_q;

  // saturates one past the limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 idle_q <= '0;
    else if (clr_i)              idle_q <= '0;
    else if (idle_q <= IDLE_LIM) idle_q <= idle_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                chk_q <= '0;
    else if (chk_q == CHK_LAST) chk_q <= '0;
    else                        chk_q <= chk_q + 1'b1;
  end

  assign idle_over_o = (idle_q > IDLE_LIM);
  assign tick_o      = (chk_q == CHK_LAST);

  AST_IDLE_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q <= IDLE_LIM + 1'b1) else $error("idle count overran"); // R7
endmodule

// File: rtl/fpc_bank_sel.sv
module fpc_bank_sel #(
  parameter int NUM_BANKS = 4,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [NUM_BANKS-1:0] present_i,
  input  logic [BW-1:0]        cur_i,
  input  logic                 from_start_i,
  output logic                 found_o,
  output logic [BW-1:0]        nxt_o
);
  // lowest present bank above cur_i, or lowest overall from start
  always_comb begin
    found_o = 1'b0;
    nxt_o   = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (present_i[i] && (from_start_i || (BW'(i) > cur_i))) begin
        found_o = 1'b1;
        nxt_o   = BW'(i);
      end
    end
  end
endmodule

// File: rtl/flash_idle_pwr_ctrl.sv
module flash_idle_pwr_ctrl
  import flash_pwr_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int CYC_PER_US = 100,
  parameter int IDLE_US    = 200000,
  parameter int CHECK_US   = 100000,
  parameter int SETTLE_US  = 50000,
  parameter int GAP_US     = 1000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 activity_i,
  input  logic                 access_req_i,
  input  logic                 access_busy_i,
  input  logic [NUM_BANKS-1:0] bank_present_i,
  input  logic                 rst_ack_i,
  input  logic                 rst_err_i,
  output logic                 supply_en_o,
  output logic                 pad_en_o,
  output logic [NUM_BANKS-1:0] bank_rst_o,
  output logic                 grant_o,
  output logic                 fatal_o
);
  localparam int IDLE_CYC   = IDLE_US * CYC_PER_US;
  localparam int CHECK_CYC  = CHECK_US * CYC_PER_US;
  localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
  localparam int GAP_CYC    = GAP_US * CYC_PER_US;
  localparam int TMAX       = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
  localparam int TW         = $clog2(TMAX + 1);
  localparam int BW         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  pwr_st_e       st_q, st_d;
  logic [BW-1:0] cur_q, cur_d, nxt;
  logic          found, tmr_load, tmr_zero, idle_clr, idle_over, tick;
  logic [TW-1:0] tmr_val;

  fpc_timer #(.TW(TW)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  fpc_idle_mon #(.IDLE_CYC(IDLE_CYC), .CHECK_CYC(CHECK_CYC)) u_idle (
    .clk_i, .rst_ni, .clr_i(idle_clr), .idle_over_o(idle_over), .tick_o(tick)
  );

  fpc_bank_sel #(.NUM_BANKS(NUM_BANKS)) u_sel (
    .present_i(bank_present_i), .cur_i(cur_q),
    .from_start_i(st_q == ST_SETTLE), .found_o(found), .nxt_o(nxt)
  );

  always_comb begin
    st_d     = st_q;
    cur_d    = cur_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    idle_clr = activity_i;
    unique case (st_q)
      ST_OFF: if (access_req_i) begin
        st_d     = ST_SETTLE;
        tmr_load = 1'b1;
        tmr_val  = TW'(SETTLE_CYC - 1);
        idle_clr = 1'b1;
      end
      ST_SETTLE, ST_GAP: if (tmr_zero) begin
        if (found) begin
          st_d  = ST_RST;
          cur_d = nxt;
        end else begin
          st_d     = ST_ON;
          idle_clr = 1'b1;
        end
      end
      ST_RST: if (rst_ack_i) begin
        if (rst_err_i) st_d = ST_FAULT;
        else begin
          st_d     = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = TW'(GAP_CYC - 1);
        end
      end
      ST_ON: if (tick && idle_over && !access_busy_i) st_d = ST_OFF;
      ST_FAULT: st_d = ST_FAULT;
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OFF;
      cur_q <= '0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
    end
  end

  assign supply_en_o = (st_q != ST_OFF);
  assign pad_en_o    = (st_q != ST_OFF);
  assign grant_o     = (st_q == ST_ON);
  assign fatal_o     = (st_q == ST_FAULT);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_rst
    assign bank_rst_o[b] = (st_q == ST_RST) && (cur_q == BW'(b));
  end

  AST_RST_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_rst_o)) else $error("multiple bank resets"); // R4
  AST_RST_PRESENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_rst_o & ~bank_present_i) == '0) else $error("absent bank reset"); // R4
  AST_GRANT_POWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> supply_en_o && pad_en_o) else $error("grant unpowered"); // R6
  AST_OFF_FROM_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(supply_en_o) |-> $past(grant_o) && $past(tick) && $past(idle_over))
    else $error("power dropped outside idle tick"); // R7
  AST_NO_DROP_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(supply_en_o) |-> !$past(access_busy_i)) else $error("dropped while busy"); // R8
  AST_FATAL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o && !grant_o) else $error("fatal cleared"); // R9
endmodule

// File: tb/test_flash_idle_pwr_ctrl.sv
module test_flash_idle_pwr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int CPU = 2;
  localparam int IDLE_C = 40 * CPU, CHECK_C = 15 * CPU, SETTLE_C = 10 * CPU, GAP_C = 3 * CPU;

  logic clk = 0, rst_n = 0;
  logic activity = 0, req = 0, busy = 0, ack = 0, err = 0, err_mode = 0;
  logic [NB-1:0] present = '0;
  logic supply, pad, grant, fatal;
  logic [NB-1:0] brst;

  int total = 0, bad = 0, cyc = 0;

  flash_idle_pwr_ctrl #(
    .NUM_BANKS(NB), .CYC_PER_US(CPU), .IDLE_US(40), .CHECK_US(15),
    .SETTLE_US(10), .GAP_US(3)
  ) i_flash_idle_pwr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .activity_i(activity), .access_req_i(req),
    .access_busy_i(busy), .bank_present_i(present), .rst_ack_i(ack),
    .rst_err_i(err), .supply_en_o(supply), .pad_en_o(pad), .bank_rst_o(brst),
    .grant_o(grant), .fatal_o(fatal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: 0 off,1 settle,2 reset,3 gap,4 on,5 fault
  int m_st = 0, m_tmr = 0, m_cur = 0, m_idle = 0, m_chk = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_tmr = 0; m_cur = 0; m_idle = 0; m_chk = 0;
    end else begin
      automatic int nst = m_st, ntmr = (m_tmr > 0) ? m_tmr - 1 : 0, ncur = m_cur;
      automatic bit clr = activity;
      automatic bit tick = (m_chk == CHECK_C - 1);
      automatic int nb = -1;
      if (m_st == 1 || m_st == 3)
        for (int i = NB - 1; i >= 0; i--)
          if (present[i] && (m_st == 1 || i > m_cur)) nb = i;
      case (m_st)
        0: if (req) begin nst = 1; ntmr = SETTLE_C - 1; clr = 1; end
        1, 3: if (m_tmr == 0) begin
          if (nb >= 0) begin nst = 2; ncur = nb; end
          else begin nst = 4; clr = 1; end
        end
        2: if (ack) begin
          if (err) nst = 5;
          else begin nst = 3; ntmr = GAP_C - 1; end
        end
        4: if (tick && m_idle > IDLE_C && !busy) nst = 0;
        default: ;
      endcase
      if (clr) m_idle = 0; else if (m_idle <= IDLE_C) m_idle++;
      m_chk = tick ? 0 : m_chk + 1;
      m_st = nst; m_tmr = ntmr; m_cur = ncur;
    end
  end

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req_tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      automatic logic [NB-1:0] eb = (m_st == 2) ? NB'(1 << m_cur) : '0;
      chk(supply == (m_st != 0), "R2/R7/R10", "supply", supply, m_st != 0);
      chk(pad == (m_st != 0), "R10", "pad", pad, m_st != 0);
      chk(grant == (m_st == 4), "R6", "grant", grant, m_st == 4);
      chk(brst == eb, "R4", "bank_rst", brst, eb);
      chk(fatal == (m_st == 5), "R9", "fatal", fatal, m_st == 5);
    end
  end

  // bank responder: acknowledge two cycles after a request
  int rwait = 0;
  always @(negedge clk) begin
    if (ack) begin ack = 0; err = 0; end
    else if (|brst) begin
      rwait++;
      if (rwait == 2) begin ack = 1; err = err_mode; rwait = 0; end
    end else rwait = 0;
  end

  // observation of request order and timing
  int order_q[$];
  logic [NB-1:0] brst_prev = '0;
  int since_sup = -1, since_fall = -1, settle_seen = -1, gap_seen = -1;
  always @(negedge clk) begin
    if (supply && since_sup < 0) since_sup = 0;
    else if (since_sup >= 0) since_sup++;
    if (since_fall >= 0) since_fall++;
    for (int i = 0; i < NB; i++) if (brst[i] && !brst_prev[i]) begin
      order_q.push_back(i);
      if (settle_seen < 0) settle_seen = since_sup;
      else if (gap_seen < 0) gap_seen = since_fall;
    end
    if (brst_prev != 0 && brst == 0) since_fall = 0;
    brst_prev = brst;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : wdog
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_cyc(3);
    chk(!supply && !pad && !grant && brst == 0 && !fatal, "R1", "outputs in reset",
        {supply, pad, grant, fatal}, 0);
    rst_n = 1;
    wait_cyc(2);
    chk(!supply && !grant, "R1", "outputs after reset", {supply, grant}, 0);

    // activity alone does not power up
    activity = 1; wait_cyc(1); activity = 0; wait_cyc(3);
    chk(!supply && !pad, "R10", "activity while off", supply, 0);

    // power-up with sparse mask
    present = 4'b1011;
    req = 1; wait_cyc(1); req = 0;
    chk(supply && pad && !grant, "R2", "powered after request", {supply, grant}, 2);
    for (int k = 0; k < 200 && !grant; k++) wait_cyc(1);
    chk(grant, "R6", "grant after sequence", grant, 1);
    chk(order_q.size() == 3, "R4", "bank reset count", order_q.size(), 3);
    if (order_q.size() == 3) begin
      chk(order_q[0] == 0, "R4", "first bank", order_q[0], 0);
      chk(order_q[1] == 1, "R4", "second bank", order_q[1], 1);
      chk(order_q[2] == 3, "R4", "third bank", order_q[2], 3);
    end
    chk(settle_seen == SETTLE_C, "R3", "settle cycles", settle_seen, SETTLE_C);
    chk(gap_seen == GAP_C, "R5", "gap cycles", gap_seen, GAP_C);

    // busy holds power across idle limit
    busy = 1;
    for (int k = 0; k < 3; k++) begin
      activity = 1; wait_cyc(1); activity = 0; wait_cyc(20);
    end
    wait_cyc(IDLE_C + 2 * CHECK_C);
    chk(supply && grant, "R8", "power kept while busy", supply, 1);
    busy = 0;
    wait_cyc(CHECK_C + 2);
    chk(!supply && !pad && !grant, "R7", "power off after idle", supply, 0);

    // empty mask grants straight after settle
    present = '0;
    req = 1; wait_cyc(1); req = 0;
    wait_cyc(SETTLE_C);
    chk(grant, "R6", "grant with no banks", grant, 1);
    wait_cyc(IDLE_C + 2 * CHECK_C + 4);
    chk(!supply, "R7", "off again", supply, 0);

    // failing bank
    present = 4'b0100; err_mode = 1;
    req = 1; wait_cyc(1); req = 0;
    wait_cyc(SETTLE_C + 6);
    chk(fatal && !grant, "R9", "fatal on reset error", fatal, 1);
    req = 1; wait_cyc(IDLE_C + 2 * CHECK_C); req = 0;
    chk(fatal && !grant, "R9", "fatal sticky", fatal, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule